// File: doc/BRIEF.md
# Read-to-Clear Interrupt Flag Controller

This block gathers three event sources into one status byte and drives a shared, active-low interrupt request. The three sources are a periodic tick, an alarm match and an update-ended notice. Each event sets its own flag whether or not software has enabled it, so the flags can be polled. A flag whose enable is also set pulls the interrupt request low. The request is open-drain: the block either drives a low level or releases the line.

Software learns which sources fired by reading the status byte. A read is framed by a begin strobe and an end strobe. The begin strobe captures the status value, and that value is presented unchanged until the read ends. When the read ends, every flag is cleared. Events that arrive while the read is open are held back, then applied as flags once the read has finished, so none of them is lost.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags are clear, `stat_o` is 0x00, `irq_oe_o` is 0 and `irq_n_o` is 1.
- R2: A one-cycle event pulse outside a read sets its flag on the next clock edge, whatever its enable is. Status bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag.
- R3: Status bits 3 to 0 always read 0.
- R4: `irq_oe_o` is 1 and `irq_n_o` is 0 exactly while at least one source has both its flag and its enable set. Otherwise `irq_oe_o` is 0 and `irq_n_o` is 1.
- R5: Status bit 7 is 1 exactly when the request is being driven. This holds for the value seen outside a read and for the captured value.
- R6: Setting an enable while its flag is already 1 drives the request in the same cycle, with no clock edge in between.
- R7: `rd_begin_i` captures the status value at the edge where it is sampled. Until that read ends, `stat_o` shows the captured value, and events do not change it.
- R8: `rd_end_i` clears every flag and status bit 7, and releases the request unless an event is still held.
- R9: An event that arrives from the `rd_begin_i` cycle through the `rd_end_i` cycle is held. It appears as a set flag on the edge that ends the read.
- R10: `rd_end_i` with no read open has no effect. A second `rd_begin_i` during an open read does not capture a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_periodic_i | input | 1 | Periodic event pulse |
| evt_alarm_i | input | 1 | Alarm event pulse |
| evt_update_i | input | 1 | Update-ended event pulse |
| en_periodic_i | input | 1 | Periodic interrupt enable |
| en_alarm_i | input | 1 | Alarm interrupt enable |
| en_update_i | input | 1 | Update-ended interrupt enable |
| rd_begin_i | input | 1 | Status read begins |
| rd_end_i | input | 1 | Status read ends; clears the flags |
| stat_o | output | 8 | Status byte: request, three flags, zero bits |
| irq_n_o | output | 1 | Interrupt request level, active low |
| irq_oe_o | output | 1 | Drive enable for the open-drain request |

## Verification
The hardest case to reach from the ports is an event that lands inside an open read. It has to leave the captured value alone, then reappear as a flag exactly on the edge that closes the read. The stimulus opens a read while one flag is set and enabled, and pulses a different source while the read is open. It then checks that `stat_o` still shows the captured byte, and after the end strobe that only the held flag remains. Further scenarios fire an event on the begin cycle and on the end cycle, and send a stray end strobe and a repeated begin strobe.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int NUM_SRC = 3;
    localparam int STAT_W  = 8;
    localparam int FLAG_LSB = 4;
    localparam int IRQ_BIT  = STAT_W - 1;
    localparam int ZERO_W   = FLAG_LSB;

    typedef struct packed {
        logic flag;
        logic held;
    } src_state_t;

    typedef struct packed {
        logic              busy;
        logic [STAT_W-1:0] snap;
    } rd_state_t;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic rd_open_i,
    input  logic rd_busy_i,
    input  logic rd_close_i,
    output logic flag_o
);
    src_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_close_i) begin
            st_d.flag = st_q.held | evt_i;
            st_d.held = 1'b0;
        end else if (rd_open_i || rd_busy_i) begin
            st_d.held = st_q.held | evt_i;
        end else begin
            st_d.flag = st_q.flag | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/irq_drive.sv
module irq_drive
    import irq_flag_pkg::*;
(
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic               act_o,
    output logic               irq_n_o,
    output logic               irq_oe_o
);
    always_comb begin
        act_o    = |(flags_i & en_i);
        irq_oe_o = act_o;
        irq_n_o  = ~act_o;
    end
endmodule

// File: rtl/irq_read_ctrl.sv
module irq_read_ctrl
    import irq_flag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_begin_i,
    input  logic               rd_end_i,
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic               irq_act_i,
    output logic               open_o,
    output logic               busy_o,
    output logic               close_o,
    output logic [STAT_W-1:0]  stat_o
);
    rd_state_t st_d, st_q;
    logic [STAT_W-1:0] live;

    always_comb begin
        live = {irq_act_i, flags_i, {ZERO_W{1'b0}}};
        open_o  = rd_begin_i & ~st_q.busy;
        close_o = rd_end_i & (st_q.busy | open_o);
        st_d = st_q;
        if (open_o) st_d.snap = live;
        if (close_o)     st_d.busy = 1'b0;
        else if (open_o) st_d.busy = 1'b1;
        stat_o = st_q.busy ? st_q.snap : live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_periodic_i,
    input  logic              evt_alarm_i,
    input  logic              evt_update_i,
    input  logic              en_periodic_i,
    input  logic              en_alarm_i,
    input  logic              en_update_i,
    input  logic              rd_begin_i,
    input  logic              rd_end_i,
    output logic [STAT_W-1:0] stat_o,
    output logic              irq_n_o,
    output logic              irq_oe_o
);
    logic [NUM_SRC-1:0] evts, ens, flags;
    logic rd_open, rd_busy, rd_close, irq_act;

    assign evts = {evt_periodic_i, evt_alarm_i, evt_update_i};
    assign ens  = {en_periodic_i, en_alarm_i, en_update_i};

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_src_cell u_cell (
            .clk(clk), .rst_n(rst_n), .evt_i(evts[g]),
            .rd_open_i(rd_open), .rd_busy_i(rd_busy), .rd_close_i(rd_close),
            .flag_o(flags[g])
        );
    end

    irq_drive u_drive (
        .flags_i(flags), .en_i(ens), .act_o(irq_act),
        .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
    );

    irq_read_ctrl u_rd (
        .clk(clk), .rst_n(rst_n), .rd_begin_i(rd_begin_i), .rd_end_i(rd_end_i),
        .flags_i(flags), .irq_act_i(irq_act), .open_o(rd_open), .busy_o(rd_busy),
        .close_o(rd_close), .stat_o(stat_o)
    );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
    import irq_flag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              evt_periodic_i,
    input logic              en_periodic_i,
    input logic              rd_begin_i,
    input logic              rd_busy,
    input logic              rd_close,
    input logic [NUM_SRC-1:0] flags,
    input logic [STAT_W-1:0] stat_o,
    input logic              irq_n_o,
    input logic              irq_oe_o
);
    // R4
    irq_level_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe_o == !irq_n_o);
    // R3
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[ZERO_W-1:0] == '0);
    // R5
    bit7_tracks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy |-> stat_o[IRQ_BIT] == irq_oe_o);
    // R7
    snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && $past(rd_busy)) |-> $stable(stat_o));
    // R2
    idle_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_periodic_i && !rd_busy && !rd_begin_i) |=> flags[NUM_SRC-1]);
    // R6
    enable_rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_periodic_i && flags[NUM_SRC-1]) |-> irq_oe_o);
    // R8
    flags_fall_only_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(flags) & ~flags) != '0) |-> $past(rd_close));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_periodic_i(evt_periodic_i),
    .en_periodic_i(en_periodic_i), .rd_begin_i(rd_begin_i), .rd_busy(rd_busy),
    .rd_close(rd_close), .flags(flags), .stat_o(stat_o),
    .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    logic clk = 0, rst_n = 0;
    logic evt_p = 0, evt_a = 0, evt_u = 0;
    logic en_p = 0, en_a = 0, en_u = 0;
    logic rd_b = 0, rd_e = 0;
    logic [7:0] stat;
    logic irq_n, irq_oe;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_periodic_i(evt_p), .evt_alarm_i(evt_a),
        .evt_update_i(evt_u), .en_periodic_i(en_p), .en_alarm_i(en_a),
        .en_update_i(en_u), .rd_begin_i(rd_b), .rd_end_i(rd_e),
        .stat_o(stat), .irq_n_o(irq_n), .irq_oe_o(irq_oe)
    );

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic chk(string req, logic [7:0] exp_stat, logic exp_oe);
        checks++;
        if (stat !== exp_stat || irq_oe !== exp_oe || irq_n !== !exp_oe) begin
            errors++;
            $display("FAIL %s: stat=%h oe=%b irq_n=%b expected stat=%h oe=%b irq_n=%b",
                     req, stat, irq_oe, irq_n, exp_stat, exp_oe, !exp_oe);
        end
    endtask

    task automatic do_read();
        rd_b = 1; tick(); rd_b = 0;
        rd_e = 1; tick(); rd_e = 0;
    endtask

    task automatic t_reset();
        chk("R1 reset", 8'h00, 0);
    endtask

    task automatic t_poll();
        evt_p = 1; tick(); evt_p = 0;
        chk("R2 periodic sets without enable", 8'h40, 0);
        evt_a = 1; evt_u = 1; tick(); evt_a = 0; evt_u = 0;
        chk("R2 R3 alarm and update bits", 8'h70, 0);
        do_read();
        chk("R8 clear after read", 8'h00, 0);
    endtask

    task automatic t_enable();
        evt_u = 1; tick(); evt_u = 0;
        en_a = 1; #1;
        chk("R4 enable without flag", 8'h10, 0);
        en_u = 1; #1;
        chk("R6 R5 enable with flag set", 8'h90, 1);
        en_u = 0; #1;
        chk("R4 release on disable", 8'h10, 0);
        en_a = 0;
        do_read();
        chk("R8 clear", 8'h00, 0);
    endtask

    task automatic t_hold();
        en_p = 1;
        evt_p = 1; tick(); evt_p = 0;
        chk("R4 driven", 8'hC0, 1);
        rd_b = 1; tick(); rd_b = 0;
        chk("R7 snapshot", 8'hC0, 1);
        evt_a = 1; tick(); evt_a = 0;
        chk("R7 stable under event", 8'hC0, 1);
        rd_e = 1; tick(); rd_e = 0;
        chk("R9 held alarm appears, R8 periodic cleared", 8'h20, 0);
        rd_b = 1; evt_u = 1; tick(); rd_b = 0; evt_u = 0;
        chk("R7 snapshot excludes begin-cycle event", 8'h20, 0);
        rd_e = 1; evt_p = 1; tick(); rd_e = 0; evt_p = 0;
        chk("R9 begin and end cycle events held", 8'hD0, 1);
        en_p = 0;
        do_read();
        chk("R8 clear", 8'h00, 0);
    endtask

    task automatic t_stray();
        evt_u = 1; tick(); evt_u = 0;
        rd_e = 1; tick(); rd_e = 0;
        chk("R10 stray end ignored", 8'h10, 0);
        rd_b = 1; tick(); rd_b = 0;
        evt_p = 1; tick(); evt_p = 0;
        rd_b = 1; tick(); rd_b = 0;
        chk("R10 second begin keeps snapshot", 8'h10, 0);
        rd_e = 1; tick(); rd_e = 0;
        chk("R9 held periodic", 8'h40, 0);
        do_read();
        chk("R8 clear", 8'h00, 0);
    endtask

    initial begin
        #1;
        t_reset();
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_poll();
        t_enable();
        t_hold();
        t_stray();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule